// File: doc/BRIEF.md
# Chip-select transaction engine for an external peripheral bus

The block runs one read or write at a time on an external peripheral bus behind a single chip select. A host raises a one-cycle request carrying an address, write data, a direction and a 27-bit configuration word. The block captures all of these when it accepts the request. It then sequences the bus, and it answers with a one-cycle done pulse and, for reads, the returned data.

The configuration word chooses one of two timings. In the multiplexed timing, an address phase comes first, marked by the address latch enable, and a data phase follows on the same lines. In the direct timing, the address appears on dedicated address lines for the whole data phase. The word also sets the address width, the data width, two bank bits, whether the peripheral's ACK may cut the wait short, and which 8-bit wait field or joined 16-bit wait value applies to reads and to writes. A request that cannot be carried out finishes at once with an error and leaves the bus untouched.

Top module: `lb_cs_engine`

## Requirements
- R1: Configuration word layout: [7:0] wait_lo, [15:8] wait_hi, [16] mux_mode, [17] ack_use, [18] cs_enable, [20:19] addr_size, [22:21] data_size, [24:23] bank, [26:25] wait_mode. After reset, cs_no, rd_no and wr_no are 1, and ale_o and done_o are 0.
- R2: In multiplexed mode, ale_o is high for exactly one cycle with cs_no high. During that cycle ad_o drives the full 32-bit address, except that lines 26:25 carry bank, with config bit 24 on line 26. In the cycle after ale_o falls, cs_no goes low.
- R3: In direct mode, ale_o stays low. While cs_no is low, la_o carries the address masked by addr_size (00: low 8 bits, 01: low 16, 10: low 24, 11: all 32). Outside that window la_o is 0.
- R4: The data phase, in which cs_no is low, lasts W+1 cycles, where W is the selected wait count. rd_no is low throughout a read and wr_no is low throughout a write.
- R5: Selection of W by wait_mode: 00 uses wait_lo for reads and writes. 01 uses wait_lo for reads and wait_hi for writes. 10 uses wait_lo for reads and {wait_hi,wait_lo} for writes. 11 uses {wait_hi,wait_lo} for both.
- R6: When mux_mode and ack_use are both 1, ack_ni sampled low at a clock edge during the data phase ends the data phase at that edge.
- R7: ack_ni has no effect when ack_use is 0 or when mux_mode is 0.
- R8: Read data is taken from ad_i at the edge that ends the data phase and is zero-extended by data_size (00: 1 byte, 01: 2 bytes, 11: 4 bytes). It is presented on rdata_o while done_o is high.
- R9: During a write data phase, ad_o carries wdata masked by data_size and ad_oe_o is 1. During a read data phase, ad_oe_o is 0.
- R10: A request with cs_enable equal to 0, or with data_size equal to 10, raises done_o and err_o together in the next cycle. cs_no, ale_o and the strobes stay inactive.
- R11: done_o is a one-cycle pulse in the cycle after the data phase ends, with cs_no high. Requests are accepted only when the engine is idle, and a request raised while a transaction is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host request, sampled while idle |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 32 | Transaction address |
| wdata_i | input | 32 | Write data |
| cfg_i | input | 27 | Configuration word (R1 layout) |
| rdata_o | output | 32 | Read data, valid with done_o |
| done_o | output | 1 | Completion pulse |
| err_o | output | 1 | Rejected request, valid with done_o |
| ad_o | output | 32 | Shared address/data lines, output value |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | 32 | Shared address/data lines, input value |
| la_o | output | 32 | Direct-mode address lines |
| ale_o | output | 1 | Address latch enable |
| cs_no | output | 1 | Chip select, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| ack_ni | input | 1 | Peripheral acknowledge, active low |

## Verification
ACK termination and read-data capture can fall in the same cycle, because ACK also decides which edge samples ad_i. The bench pulls ack_ni low after a chosen number of chip-select cycles that is well short of the programmed wait. It then checks that the data phase has exactly that length and that rdata_o holds ad_i masked to the configured width. A second collision is a new request that arrives while a transaction is still running. The bench judges it by counting done pulses and chip-select cycles across the whole window.

// File: rtl/lb_cs_pkg.sv
package lb_cs_pkg;
  localparam int BUS_W    = 32;
  localparam int CFG_W    = 27;
  localparam int BANK_LSB = 25;

  typedef struct packed {
    logic [1:0] wait_mode;
    logic [1:0] bank;
    logic [1:0] data_size;
    logic [1:0] addr_size;
    logic       cs_enable;
    logic       ack_use;
    logic       mux_mode;
    logic [7:0] wait_hi;
    logic [7:0] wait_lo;
  } cs_cfg_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_GAP} cs_state_e;

  function automatic logic [BUS_W-1:0] byte_mask(input logic [1:0] code);
    case (code)
      2'b00:   byte_mask = BUS_W'(32'h0000_00ff);
      2'b01:   byte_mask = BUS_W'(32'h0000_ffff);
      2'b10:   byte_mask = BUS_W'(32'h00ff_ffff);
      default: byte_mask = '1;
    endcase
  endfunction
endpackage

// File: rtl/lb_wait_sel.sv
module lb_wait_sel #(
  parameter int WAIT_W = 8,
  localparam int CNT_W = 2 * WAIT_W
) (
  input  logic [1:0]        wait_mode_i,
  input  logic              wr_i,
  input  logic [WAIT_W-1:0] wait_hi_i,
  input  logic [WAIT_W-1:0] wait_lo_i,
  output logic [CNT_W-1:0]  wait_o
);
  logic [CNT_W-1:0] lo_ext, hi_ext, joined;

  assign lo_ext = {{WAIT_W{1'b0}}, wait_lo_i};
  assign hi_ext = {{WAIT_W{1'b0}}, wait_hi_i};
  assign joined = {wait_hi_i, wait_lo_i};

  always_comb begin
    case (wait_mode_i)
      2'b00:   wait_o = lo_ext;
      2'b01:   wait_o = wr_i ? hi_ext : lo_ext;
      2'b10:   wait_o = wr_i ? joined : lo_ext;
      default: wait_o = joined;
    endcase
  end
endmodule

// File: rtl/lb_bus_fmt.sv
module lb_bus_fmt
  import lb_cs_pkg::*;
(
  input  cs_state_e        st_i,
  input  cs_cfg_t          cfg_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  output logic [BUS_W-1:0] la_o
);
  logic [BUS_W-1:0] bank_field, bank_clr;

  assign bank_field = BUS_W'(cfg_i.bank) << BANK_LSB;
  assign bank_clr   = ~(BUS_W'(2'b11) << BANK_LSB);

  always_comb begin
    ad_o    = '0;
    ad_oe_o = 1'b0;
    la_o    = '0;
    case (st_i)
      ST_ADDR: begin
        // full address regardless of addr_size, bank overlaid
        ad_o    = (addr_i & bank_clr) | bank_field;
        ad_oe_o = 1'b1;
      end
      ST_DATA: begin
        if (wr_i) begin
          ad_o    = wdata_i & byte_mask(cfg_i.data_size);
          ad_oe_o = 1'b1;
        end
        if (!cfg_i.mux_mode) la_o = addr_i & byte_mask(cfg_i.addr_size);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lb_seq.sv
module lb_seq
  import lb_cs_pkg::*;
#(
  parameter int WAIT_W = 8,
  localparam int CNT_W = 2 * WAIT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  cs_cfg_t          cfg_i,
  input  logic [CNT_W-1:0] wait_i,
  input  logic             ack_ni,
  input  logic [BUS_W-1:0] ad_i,
  output cs_state_e        st_o,
  output cs_cfg_t          cfg_o,
  output logic             wr_o,
  output logic [BUS_W-1:0] addr_o,
  output logic [BUS_W-1:0] wdata_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             ale_o,
  output logic             rd_no,
  output logic             wr_no
);
  cs_state_e        st_q;
  cs_cfg_t          cfg_q;
  logic             wr_q, err_q;
  logic [BUS_W-1:0] addr_q, wdata_q, rdata_q;
  logic [CNT_W-1:0] cnt_q;
  logic             bad_req, ack_hit, term;

  assign bad_req = !cfg_i.cs_enable || (cfg_i.data_size == 2'b10);
  assign ack_hit = cfg_q.mux_mode && cfg_q.ack_use && !ack_ni;
  assign term    = (cnt_q == '0) || ack_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cfg_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_i) begin
          cfg_q   <= cfg_i;
          wr_q    <= wr_i;
          addr_q  <= addr_i;
          wdata_q <= wdata_i;
          cnt_q   <= wait_i;
          err_q   <= bad_req;
          if (bad_req)              st_q <= ST_GAP;
          else if (cfg_i.mux_mode)  st_q <= ST_ADDR;
          else                      st_q <= ST_DATA;
        end
        ST_ADDR: st_q <= ST_DATA;
        ST_DATA: begin
          if (term) begin
            st_q <= ST_GAP;
            if (!wr_q) rdata_q <= ad_i & byte_mask(cfg_q.data_size);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o    = st_q;
  assign cfg_o   = cfg_q;
  assign wr_o    = wr_q;
  assign addr_o  = addr_q;
  assign wdata_o = wdata_q;
  assign rdata_o = rdata_q;
  assign done_o  = (st_q == ST_GAP);
  assign err_o   = (st_q == ST_GAP) && err_q;
  assign cs_no   = (st_q != ST_DATA);
  assign ale_o   = (st_q == ST_ADDR);
  assign rd_no   = !((st_q == ST_DATA) && !wr_q);
  assign wr_no   = !((st_q == ST_DATA) && wr_q);

  a_r2_cs_after_ale: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ale_o) |-> !cs_no);
  a_r4_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_no || !wr_no) |-> !cs_no);
  a_r7_direct_runs_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && !cfg_q.mux_mode && cnt_q != '0) |=> (st_q == ST_DATA));
  a_r10_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (done_o && cs_no && !ale_o));
  a_r11_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/lb_cs_engine.sv
module lb_cs_engine
  import lb_cs_pkg::*;
#(
  parameter int WAIT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [BUS_W-1:0] addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  input  logic [CFG_W-1:0] cfg_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             done_o,
  output logic             err_o,
  output logic [BUS_W-1:0] ad_o,
  output logic             ad_oe_o,
  input  logic [BUS_W-1:0] ad_i,
  output logic [BUS_W-1:0] la_o,
  output logic             ale_o,
  output logic             cs_no,
  output logic             rd_no,
  output logic             wr_no,
  input  logic             ack_ni
);
  localparam int CNT_W = 2 * WAIT_W;

  cs_cfg_t          cfg_in, cfg_q;
  cs_state_e        st;
  logic [CNT_W-1:0] wait_sel;
  logic             wr_q;
  logic [BUS_W-1:0] addr_q, wdata_q;

  assign cfg_in = cs_cfg_t'(cfg_i);

  lb_wait_sel #(.WAIT_W(WAIT_W)) u_wait (
    .wait_mode_i(cfg_in.wait_mode),
    .wr_i       (wr_i),
    .wait_hi_i  (cfg_in.wait_hi),
    .wait_lo_i  (cfg_in.wait_lo),
    .wait_o     (wait_sel)
  );

  lb_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .wr_i   (wr_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .cfg_i  (cfg_in),
    .wait_i (wait_sel),
    .ack_ni (ack_ni),
    .ad_i   (ad_i),
    .st_o   (st),
    .cfg_o  (cfg_q),
    .wr_o   (wr_q),
    .addr_o (addr_q),
    .wdata_o(wdata_q),
    .rdata_o(rdata_o),
    .done_o (done_o),
    .err_o  (err_o),
    .cs_no  (cs_no),
    .ale_o  (ale_o),
    .rd_no  (rd_no),
    .wr_no  (wr_no)
  );

  lb_bus_fmt u_fmt (
    .st_i   (st),
    .cfg_i  (cfg_q),
    .wr_i   (wr_q),
    .addr_i (addr_q),
    .wdata_i(wdata_q),
    .ad_o   (ad_o),
    .ad_oe_o(ad_oe_o),
    .la_o   (la_o)
  );

  a_r9_read_no_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> !ad_oe_o);
  a_r3_la_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> (la_o == '0));
endmodule

// File: tb/lb_cs_engine_tb.sv
module lb_cs_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0, ack_ni = 1'b1;
  logic [31:0] addr_i = '0, wdata_i = '0, ad_i = '0;
  logic [26:0] cfg_i = '0;
  logic [31:0] rdata_o, ad_o, la_o;
  logic        done_o, err_o, ad_oe_o, ale_o, cs_no, rd_no, wr_no;

  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lb_cs_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .cfg_i(cfg_i), .rdata_o(rdata_o), .done_o(done_o),
    .err_o(err_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i), .la_o(la_o),
    .ale_o(ale_o), .cs_no(cs_no), .rd_no(rd_no), .wr_no(wr_no), .ack_ni(ack_ni)
  );

  // results of the last transaction
  int          n_ale, n_cs, n_rd, n_wr, n_oe;
  logic [31:0] ad_at_ale, ad_at_data, la_at_data, rdata_got;
  logic        err_got, cs_at_done, done_seen;

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [26:0] mk_cfg(input logic mux, input logic ack, input logic ce,
      input logic [1:0] asz, input logic [1:0] dsz, input logic [1:0] bank,
      input logic [1:0] wmode, input logic [7:0] hi, input logic [7:0] lo);
    return {wmode, bank, dsz, asz, ce, ack, mux, hi, lo};
  endfunction

  function automatic logic [31:0] msk(input logic [1:0] c);
    case (c)
      2'b00: return 32'h0000_00ff;
      2'b01: return 32'h0000_ffff;
      2'b10: return 32'h00ff_ffff;
      default: return 32'hffff_ffff;
    endcase
  endfunction

  // ack_at: drop ack after that many chip-select cycles (0 = never)
  task automatic run_txn(input logic [26:0] cfg, input logic wr, input logic [31:0] addr,
                         input logic [31:0] wdata, input int ack_at);
    n_ale = 0; n_cs = 0; n_rd = 0; n_wr = 0; n_oe = 0;
    ad_at_ale = 'x; ad_at_data = 'x; la_at_data = 'x;
    done_seen = 1'b0;
    @(negedge clk);
    cfg_i = cfg; wr_i = wr; addr_i = addr; wdata_i = wdata; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    for (int i = 0; i < 70000; i++) begin
      if (ale_o) begin n_ale++; ad_at_ale = ad_o; end
      if (!cs_no) begin
        n_cs++; ad_at_data = ad_o; la_at_data = la_o;
        if (ad_oe_o) n_oe++;
        if (!rd_no) n_rd++;
        if (!wr_no) n_wr++;
        if (ack_at != 0 && n_cs == ack_at) ack_ni = 1'b0;
      end
      if (done_o) begin
        done_seen = 1'b1; err_got = err_o; rdata_got = rdata_o; cs_at_done = cs_no;
        break;
      end
      @(negedge clk);
    end
    ack_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cs_no reset", cs_no, 1);
    check("R1 ale_o reset", ale_o, 0);
    check("R1 done_o reset", done_o, 0);
    check("R1 strobes reset", {rd_no, wr_no}, 2'b11);
  endtask

  task automatic t_mux_write();
    logic [31:0] a = 32'h1234_5678, exp_a;
    exp_a = (a & ~(32'h3 << 25)) | (32'h2 << 25);
    run_txn(mk_cfg(1, 0, 1, 2'b00, 2'b11, 2'b10, 2'b00, 8'd9, 8'd3), 1, a, 32'hcafe_f00d, 0);
    check("R2 ale one cycle", n_ale, 1);
    check("R2 address with bank", ad_at_ale, exp_a);
    check("R4 R5 mux write length", n_cs, 4);
    check("R4 write strobe", n_wr, 4);
    check("R4 no read strobe", n_rd, 0);
    check("R9 write data", ad_at_data, 32'hcafe_f00d);
    check("R9 oe in write", n_oe, 4);
    check("R11 done no err", {done_seen, err_got}, 2'b10);
  endtask

  task automatic t_mux_bank_low();
    run_txn(mk_cfg(1, 0, 1, 2'b00, 2'b00, 2'b01, 2'b00, 8'd0, 8'd0), 1, 32'hffff_ffff,
            32'hffff_ff5a, 0);
    check("R2 bank 01 on lines 26:25", ad_at_ale, 32'hfbff_ffff);
    check("R9 byte write masked", ad_at_data, 32'h0000_005a);
  endtask

  task automatic t_direct_read();
    ad_i = 32'hdead_beef;
    run_txn(mk_cfg(0, 0, 1, 2'b01, 2'b01, 2'b11, 2'b01, 8'd7, 8'd2), 0, 32'habcd_1234, 0, 0);
    check("R3 no ale in direct", n_ale, 0);
    check("R3 la masked 16", la_at_data, 32'h0000_1234);
    check("R5 read uses lo in mode01", n_cs, 3);
    check("R9 no oe in read", n_oe, 0);
    check("R4 read strobe", n_rd, 3);
    check("R8 read 2 bytes", rdata_got, 32'h0000_beef);
    check("R3 la zero after", la_o, 0);
    run_txn(mk_cfg(0, 0, 1, 2'b10, 2'b11, 2'b00, 2'b00, 8'd0, 8'd1), 0, 32'habcd_1234, 0, 0);
    check("R3 la masked 24", la_at_data, 32'h00cd_1234);
    check("R8 read 4 bytes", rdata_got, 32'hdead_beef);
  endtask

  task automatic t_wait_modes();
    run_txn(mk_cfg(0, 0, 1, 2'b11, 2'b11, 2'b00, 2'b01, 8'd7, 8'd2), 1, 0, 0, 0);
    check("R5 mode01 write uses hi", n_cs, 8);
    run_txn(mk_cfg(0, 0, 1, 2'b11, 2'b11, 2'b00, 2'b10, 8'd1, 8'd2), 1, 0, 0, 0);
    check("R5 mode10 write joined", n_cs, 259);
    run_txn(mk_cfg(0, 0, 1, 2'b11, 2'b11, 2'b00, 2'b10, 8'd1, 8'd2), 0, 0, 0, 0);
    check("R5 mode10 read lo", n_cs, 3);
    run_txn(mk_cfg(1, 0, 1, 2'b11, 2'b11, 2'b00, 2'b11, 8'd1, 8'd4), 0, 0, 0, 0);
    check("R5 mode11 read joined", n_cs, 261);
    run_txn(mk_cfg(0, 0, 1, 2'b11, 2'b11, 2'b00, 2'b00, 8'd7, 8'd5), 1, 0, 0, 0);
    check("R5 mode00 write lo", n_cs, 6);
  endtask

  task automatic t_ack();
    ad_i = 32'h8765_43a9;
    run_txn(mk_cfg(1, 1, 1, 2'b00, 2'b00, 2'b00, 2'b00, 8'd0, 8'd20), 0, 32'h10, 0, 3);
    check("R6 ack ends early", n_cs, 3);
    check("R8 read at ack byte", rdata_got, 32'h0000_00a9);
    check("R11 cs high at done", cs_at_done, 1);
    run_txn(mk_cfg(1, 0, 1, 2'b00, 2'b11, 2'b00, 2'b00, 8'd0, 8'd5), 0, 0, 0, 2);
    check("R7 ack ignored ack_use=0", n_cs, 6);
    run_txn(mk_cfg(0, 1, 1, 2'b00, 2'b11, 2'b00, 2'b00, 8'd0, 8'd5), 0, 0, 0, 2);
    check("R7 ack ignored direct", n_cs, 6);
  endtask

  task automatic t_errors();
    run_txn(mk_cfg(1, 0, 0, 2'b00, 2'b11, 2'b00, 2'b00, 8'd0, 8'd3), 1, 0, 0, 0);
    check("R10 disabled err", {done_seen, err_got}, 2'b11);
    check("R10 disabled no bus", n_cs + n_ale, 0);
    run_txn(mk_cfg(0, 0, 1, 2'b00, 2'b10, 2'b00, 2'b00, 8'd0, 8'd3), 0, 0, 0, 0);
    check("R10 bad size err", {done_seen, err_got}, 2'b11);
    check("R10 bad size no bus", n_cs + n_rd + n_wr, 0);
  endtask

  task automatic t_busy_req();
    int dones = 0, cs_low = 0, done_len = 0;
    @(negedge clk);
    cfg_i = mk_cfg(0, 0, 1, 2'b11, 2'b11, 2'b00, 2'b00, 8'd0, 8'd6);
    wr_i = 1'b1; addr_i = 32'h100; req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (i == 2) begin req_i = 1'b1; addr_i = 32'h200; end
      if (i == 3) req_i = 1'b0;
      if (!cs_no) begin
        cs_low++;
        if (la_o != 32'h100) check("R11 busy req ignored addr", la_o, 32'h100);
      end
      if (done_o) begin dones++; done_len++; end
      @(negedge clk);
    end
    check("R11 single done", dones, 1);
    check("R11 done one cycle", done_len, 1);
    check("R11 busy req ignored", cs_low, 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_mux_write();
    t_mux_bank_low();
    t_direct_read();
    t_wait_modes();
    t_ack();
    t_errors();
    t_busy_req();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule